// File: doc/BRIEF.md
# Hysteretic Count Width Extender

This block turns a wrapping 16-bit quadrature position count into a signed 32-bit position. It keeps a signed base value and adds the live count to it. When the count rolls over in the same direction as the last qualified rollover, the base moves by one full span (65536). A rollover in the opposite direction is a reversal and leaves the base alone.

Noise or dithering around the rollover point can produce a burst of rollover pulses. To keep these from reaching the base, rollover handling is hysteretic. Once a rollover is taken, detection stays off until the count lands on the active compare threshold. The two thresholds sit at 3/8 and 5/8 of the range, and the active one alternates at each crossing. While detection is off, the count is read as a small positive offset or as an offset below full scale, depending on which side of the rollover it sits.

The counter is outside the block. The block sees the count, a one-cycle rollover pulse with its direction, the counter's present direction, and a zero command. The zero command clears the counter in the same cycle.

Top module: `qx_count_extender`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, `pos` reads 0.
- R2: `pos` is registered. It holds its old value until the rising edge at which a new `cnt` is sampled. After that edge it equals the true accumulated position: the signed sum of all count movements since reset or zero.
- R3: A rollover pulse with `wrap_up`=1, taken while detection is armed, adds 65536 to the base. This happens only if the last threshold crossed was the upper one and the recorded direction is up.
- R4: A rollover pulse with `wrap_up`=0, taken while detection is armed, subtracts 65536 from the base. This happens only if the last threshold crossed was the lower one and the recorded direction is down.
- R5: A taken rollover that does not meet R3 or R4 is a reversal. The base is unchanged, and `pos` still tracks the true position.
- R6: After a taken rollover, detection is disarmed. Further rollover pulses change neither the base nor the tracking of `pos` until a threshold is crossed.
- R7: A threshold crossing is the cycle in which `cnt` equals the active threshold: 0x6000 (lower) or 0xA000 (upper). A crossing records the direction of the latest rollover pulse, re-arms detection and swaps the active threshold. After a taken rollover, the lower threshold becomes active if the last crossing was at the upper threshold, and the upper one otherwise.
- R8: `zero_cmd` forces `pos` to 0 at the next edge, clears the base and disarms detection. It selects the lower threshold when `dir_up`=1 and the upper threshold when `dir_up`=0.
- R9: If a threshold is crossed with no rollover pulse seen since reset or zero, the recorded direction is taken as up.
- R10: While disarmed, the count is read as a positive offset below 0x4000 and as a negative offset (count minus 65536) above 0xC000. Between those values, the direction of the latest rollover pulse decides. While armed, the recorded direction decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | 16 | Present value of the wrapping counter |
| wrap_pls | input | 1 | One-cycle rollover pulse from the counter |
| wrap_up | input | 1 | Direction of the rollover: 1 = 0xFFFF to 0, 0 = 0 to 0xFFFF |
| dir_up | input | 1 | Present counting direction, 1 = up |
| zero_cmd | input | 1 | Zero command; the counter is cleared in the same cycle |
| pos | output | 32 | Signed extended position |

## Verification
Every result is due one rising edge after its stimulus. The count, the rollover pulse and the zero command are all sampled at that edge, and `pos` is registered from the next-state values. The bench drives each stimulus at a falling edge and reads `pos` at the following falling edge. In one case it also reads `pos` a quarter period after the drive, to confirm that the old value still holds before the edge. Expected positions are a running sum of the movements the bench applies. Zero commands reset that sum.

// File: rtl/qx_pkg.sv
package qx_pkg;

  // Which compare threshold is active or was last crossed
  typedef enum logic {
    THR_LO = 1'b0,
    THR_HI = 1'b1
  } thr_sel_e;

  function automatic thr_sel_e thr_other(input thr_sel_e t);
    return (t == THR_LO) ? THR_HI : THR_LO;
  endfunction

  // Threshold after a taken rollover: approached upward (last crossing high)
  // means the lower one comes next
  function automatic thr_sel_e thr_after_wrap(input thr_sel_e last_cross);
    return (last_cross == THR_HI) ? THR_LO : THR_HI;
  endfunction

endpackage

// File: rtl/qx_arm_ctrl.sv
module qx_arm_ctrl
  import qx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap_pls,
  input  logic             wrap_up,
  input  logic             dir_up,
  input  logic             zero_cmd,
  output logic             step_up,
  output logic             step_dn,
  output logic             armed_nx,
  output logic             last_up_nx,
  output logic             wdir_nx
);

  localparam int SPAN_I = 1 << CNT_W;
  localparam logic [CNT_W-1:0] LO_V = CNT_W'((3 * SPAN_I) / 8);
  localparam logic [CNT_W-1:0] HI_V = CNT_W'((5 * SPAN_I) / 8);

  logic     armed_q, last_up_q, seen_q, wdir_q;
  thr_sel_e thr_q, prev_q;
  logic     seen_nx;
  thr_sel_e thr_nx, prev_nx;
  logic     hit, take;
  logic [CNT_W-1:0] thr_val;

  assign thr_val = (thr_q == THR_HI) ? HI_V : LO_V;
  assign hit     = !zero_cmd && (cnt == thr_val);
  assign take    = !zero_cmd && wrap_pls && armed_q;

  always_comb begin
    armed_nx   = armed_q;
    last_up_nx = last_up_q;
    seen_nx    = seen_q;
    wdir_nx    = wdir_q;
    thr_nx     = thr_q;
    prev_nx    = prev_q;
    step_up    = 1'b0;
    step_dn    = 1'b0;
    if (zero_cmd) begin
      armed_nx   = 1'b0;
      last_up_nx = 1'b1;
      seen_nx    = 1'b0;
      wdir_nx    = 1'b1;
      thr_nx     = dir_up ? THR_LO : THR_HI;
      prev_nx    = THR_LO;
    end else begin
      if (wrap_pls) begin
        seen_nx = 1'b1;
        wdir_nx = wrap_up;
      end
      if (take) begin
        armed_nx = 1'b0;
        thr_nx   = thr_after_wrap(prev_q);
        step_up  = (prev_q == THR_HI) && last_up_q;
        step_dn  = (prev_q == THR_LO) && !last_up_q;
      end else if (hit) begin
        armed_nx   = 1'b1;
        thr_nx     = thr_other(thr_q);
        prev_nx    = thr_q;
        last_up_nx = seen_q ? wdir_q : 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      last_up_q <= 1'b1;
      seen_q    <= 1'b0;
      wdir_q    <= 1'b1;
      thr_q     <= THR_LO;
      prev_q    <= THR_LO;
    end else begin
      armed_q   <= armed_nx;
      last_up_q <= last_up_nx;
      seen_q    <= seen_nx;
      wdir_q    <= wdir_nx;
      thr_q     <= thr_nx;
      prev_q    <= prev_nx;
    end
  end

  // R3 and R4 are exclusive
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  // R6: a taken rollover leaves detection off
  a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !armed_q);

  // R7: a crossing arms and swaps the threshold
  a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (armed_q && (thr_q != $past(thr_q))));

  // R9: no rollover since zero means direction up
  a_r9_assume_up: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !seen_q) |=> last_up_q);

  // R8: zero disarms
  a_r8_zero_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cmd |=> !armed_q);

endmodule

// File: rtl/qx_base_acc.sv
module qx_base_acc #(
  parameter int CNT_W = 16,
  parameter int POS_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    zero_cmd,
  input  logic                    step_up,
  input  logic                    step_dn,
  output logic signed [POS_W-1:0] base_nx
);

  localparam logic signed [POS_W-1:0] SPAN = POS_W'(longint'(1) << CNT_W);

  logic signed [POS_W-1:0] base_q;

  always_comb begin
    if (zero_cmd)     base_nx = '0;
    else if (step_up) base_nx = base_q + SPAN;
    else if (step_dn) base_nx = base_q - SPAN;
    else              base_nx = base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_nx;
  end

  // R5/R6: base holds when no qualified step
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_cmd && !step_up && !step_dn) |=> $stable(base_q));

  a_r3_add: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_cmd && step_up) |=> (base_q == $past(base_q) + SPAN));

  a_r4_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_cmd && step_dn) |=> (base_q == $past(base_q) - SPAN));

  a_r8_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cmd |=> (base_q == '0));

endmodule

// File: rtl/qx_pos_compose.sv
module qx_pos_compose #(
  parameter int CNT_W = 16,
  parameter int POS_W = 32
) (
  input  logic signed [POS_W-1:0] base,
  input  logic [CNT_W-1:0]        cnt,
  input  logic                    armed,
  input  logic                    last_up,
  input  logic                    wdir,
  output logic signed [POS_W-1:0] pos_val
);

  localparam int SPAN_I = 1 << CNT_W;
  localparam logic [CNT_W-1:0] NEAR0_V = CNT_W'(SPAN_I / 4);
  localparam logic [CNT_W-1:0] NEART_V = CNT_W'((3 * SPAN_I) / 4);
  localparam logic signed [POS_W-1:0] SPAN = POS_W'(longint'(1) << CNT_W);

  logic neg;
  logic signed [POS_W-1:0] cnt_ext;

  assign cnt_ext = $signed({{(POS_W-CNT_W){1'b0}}, cnt});

  always_comb begin
    if (!armed) begin
      if (cnt > NEART_V)      neg = 1'b1;
      else if (cnt < NEAR0_V) neg = 1'b0;
      else                    neg = !wdir;
    end else begin
      neg = !last_up;
    end
    pos_val = base + cnt_ext - (neg ? SPAN : '0);
  end

endmodule

// File: rtl/qx_count_extender.sv
module qx_count_extender #(
  parameter int CNT_W = 16,
  parameter int POS_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        cnt,
  input  logic                    wrap_pls,
  input  logic                    wrap_up,
  input  logic                    dir_up,
  input  logic                    zero_cmd,
  output logic signed [POS_W-1:0] pos
);

  logic step_up, step_dn, armed_nx, last_up_nx, wdir_nx;
  logic signed [POS_W-1:0] base_nx, pos_val;

  qx_arm_ctrl #(.CNT_W(CNT_W)) u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt),
    .wrap_pls   (wrap_pls),
    .wrap_up    (wrap_up),
    .dir_up     (dir_up),
    .zero_cmd   (zero_cmd),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .armed_nx   (armed_nx),
    .last_up_nx (last_up_nx),
    .wdir_nx    (wdir_nx)
  );

  qx_base_acc #(.CNT_W(CNT_W), .POS_W(POS_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .zero_cmd (zero_cmd),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .base_nx  (base_nx)
  );

  qx_pos_compose #(.CNT_W(CNT_W), .POS_W(POS_W)) u_comp (
    .base    (base_nx),
    .cnt     (cnt),
    .armed   (armed_nx),
    .last_up (last_up_nx),
    .wdir    (wdir_nx),
    .pos_val (pos_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos <= '0;
    else if (zero_cmd) pos <= '0;
    else               pos <= pos_val;
  end

  // R8: zero command gives a zero position at the next edge
  a_r8_zero_pos: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cmd |=> (pos == '0));

  // R2: position only moves when the count, a rollover or zero is seen
  a_r2_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cnt) && !wrap_pls && !zero_cmd && !$past(wrap_pls)
     && !$past(zero_cmd)) |=> $stable(pos));

endmodule

// File: tb/test_qx_count_extender.sv
module test_qx_count_extender;

  localparam int CLK_NS = 10;
  localparam int NROW = 22;

  // Count movements applied from reset; expected position is their running sum
  localparam int DELTA [NROW] = '{
    'h1000,   // R10 disarmed near zero
    'h5000,   // R9 lower crossing, no rollover yet
    'h4000,   // R7 upper crossing
    'h5FFF,   // R2
    1,        // R3 qualified up rollover
    -1,       // R6 dither, ignored
    1,        // R6
    -1,       // R6
    1,        // R6
    'h6000,   // R7 lower crossing
    'h4000,   // R7 upper crossing
    'h6000,   // R3 second up rollover
    -'h2000,  // R6 down rollover ignored
    -'h4000,  // R10 mid region, disarmed
    -'h6000 + 'h2000, // R7 lower crossing going down
    -'h6000,  // R10 armed down
    -1,       // R4 qualified down rollover
    -'h5FFF,  // R7 upper crossing
    'h6000,   // R5 reversal up
    'h6000,   // R7
    -'h6000,  // R2
    -1        // R5 reversal down
  };
  localparam int REQ [NROW] = '{10,9,7,2,3,6,6,6,6,7,7,3,6,10,7,10,4,7,5,7,2,5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic wrap_pls = 1'b0, wrap_up = 1'b0, dir_up = 1'b1, zero_cmd = 1'b0;
  logic signed [31:0] pos;

  int n_chk = 0, n_bad = 0, cur = 0;
  longint ref_pos = 0;
  bit done = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  qx_count_extender i_qx_count_extender (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap_pls(wrap_pls),
    .wrap_up(wrap_up), .dir_up(dir_up), .zero_cmd(zero_cmd), .pos(pos)
  );

  task automatic chk(input int rq, input longint exp);
    n_chk++;
    if (longint'(pos) != exp) begin
      n_bad++;
      $display("FAIL R%0d: pos=%0d expected %0d", rq, pos, exp);
    end
  endtask

  task automatic mv(input int d, input int rq);
    int nc;
    @(negedge clk);
    nc = cur + d;
    wrap_pls = (nc > 65535) || (nc < 0);
    wrap_up  = (nc > 65535);
    if (nc > 65535) nc -= 65536;
    if (nc < 0)     nc += 65536;
    cnt = 16'(nc);
    dir_up = (d > 0);
    cur = nc;
    ref_pos += d;
    @(posedge clk);
    @(negedge clk);
    wrap_pls = 1'b0;
    chk(rq, ref_pos);
  endtask

  task automatic zr(input logic up);
    @(negedge clk);
    zero_cmd = 1'b1;
    dir_up = up;
    cnt = '0;
    cur = 0;
    ref_pos = 0;
    @(posedge clk);
    @(negedge clk);
    zero_cmd = 1'b0;
    chk(8, 0); // R8 zero gives 0
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R2: watchdog expired, actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset value
    repeat (3) @(negedge clk);
    chk(1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, 0);

    // Table walk
    for (int i = 0; i < NROW; i++) mv(DELTA[i], REQ[i]);

    // R2: before the edge the old value still holds
    @(negedge clk);
    cnt = 16'(cur + 5);
    #(CLK_NS / 4);
    chk(2, ref_pos);
    cur = cur + 5;
    ref_pos += 5;
    @(negedge clk);
    chk(2, ref_pos);

    // R8 zero counting down, then R4 qualified down rollover
    zr(1'b0);
    mv(-1, 6);
    mv(-'h5FFF, 7);
    mv(-'h4000, 7);
    mv(-'h6000, 10);
    mv(-1, 4);

    // R9 zero counting up, cross lower, then reverse through zero
    zr(1'b1);
    mv('h6000, 9);
    mv(-'h6000, 9);
    mv(-1, 9);     // R9/R5 assumed-up direction makes this a reversal
    mv(-'h3FFF, 10); // R10 count 0xC000 uses rollover direction

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_NS / 4);
    chk(1, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cnt = '0; cur = 0; ref_pos = 0; dir_up = 1'b1;
    @(negedge clk);
    chk(1, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule